// File: doc/BRIEF.md
# Eight-Channel Block-Transfer DMA Engine

This engine copies byte streams between a 24-bit memory-side bus (the A-bus) and a 256-register peripheral window (the B-bus). A start pulse loads an enable mask. The engine then works through the enabled channels from the lowest number to the highest. Each channel copies its programmed number of bytes in one burst. While the engine runs, it holds the processor stalled.

Each channel has its own settings: a direction, a 3-bit offset mode, a source bank and a 16-bit address, a B-bus base register, a hold flag, a count-down flag, and a byte count. The settings must stay stable while the engine is busy. Every byte takes 8 clocks: a read slot followed by a write slot. A write is held in a single pipeline stage, so the write of one byte shares a slot with the read of the next byte. The engine blocks accesses that would reach control registers on the A-bus. It also blocks copies in which both ends would land in the same work memory. A blocked access raises no strobe, and a blocked read supplies zero.

Top module: `gpdma_engine`

## Requirements
- R1: Enabled channels are served in strictly ascending channel order. Each channel copies all of its bytes before the next channel starts.
- R2: A channel's bit in `chan_en_o` clears in the cycle that follows its trailing overhead. When busy ends, every bit is zero.
- R3: The busy period lasts 8 + Σ(8·n + 8) cycles over the enabled channels, where n is the channel's byte count. `clk_cnt_o` holds this count once the run ends. A read strobe appears only in cycle 0 of a byte's 8-cycle slot.
- R4: The B register index is base + offset, where the offset depends on the mode and the byte index k. Modes 0, 2 and 6 give 0. Modes 1 and 5 give k mod 2. Modes 3 and 7 give (k/2) mod 2. Mode 4 gives k mod 4.
- R5: After each byte, the 16-bit A address stays the same if the hold flag is set. Otherwise it decrements when the count-down flag is set and increments when it is clear. It wraps within 16 bits, and the bank never changes.
- R6: The byte count is decremented once per byte and the channel ends when the count reaches zero. A starting count of 0 therefore copies 2^CNT_W bytes.
- R7: In banks with bit 22 clear, A offsets 0x2100–0x21FF, 0x4000–0x41FF, 0x4200–0x421F and 0x4300–0x437F are blocked. A read there raises no strobe and yields 0x00. A write there raises no strobe.
- R8: A transfer is invalid when the B index is 0x80 and the A address lies in work memory. Work memory is banks 0x7E–0x7F, or offsets below 0x2000 in banks with bit 22 clear. An invalid A→B transfer drops its B write. An invalid B→A transfer raises no B read and writes 0x00 to the A-bus.
- R9: Byte k of a channel whose first slot begins at busy cycle t is written in busy cycle t + 8k + 12. The write strobe lasts one cycle, and each overhead slot flushes the pipeline.
- R10: `busy_o` and `stall_o` rise in the cycle after an accepted start and fall after the last channel. A start pulse while busy has no effect.
- R11: The B-bus address is 0x2100 + index, where the index is an 8-bit sum that wraps from 0xFF to 0x00.
- R12: When direction is 0, bytes read from the A-bus are written to the B-bus. When direction is 1, bytes read from the B-bus are written to the A-bus. The written data equals the data read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse, accepted while idle |
| en_mask_i | input | NCH | Channel enables loaded at start |
| cfg_dir_i | input | NCH | Per-channel direction (0 = A→B) |
| cfg_mode_i | input | 3·NCH | Per-channel offset mode |
| cfg_fixed_i | input | NCH | Per-channel hold-address flag |
| cfg_rev_i | input | NCH | Per-channel count-down flag |
| cfg_bank_i | input | 8·NCH | Per-channel A bank |
| cfg_addr_i | input | 16·NCH | Per-channel starting A address |
| cfg_bbase_i | input | 8·NCH | Per-channel B base index |
| cfg_count_i | input | CNT_W·NCH | Per-channel byte count (0 = 2^CNT_W) |
| a_addr_o | output | 24 | A-bus address |
| a_rd_o | output | 1 | A-bus read strobe |
| a_wr_o | output | 1 | A-bus write strobe |
| a_wdata_o | output | 8 | A-bus write data |
| a_rdata_i | input | 8 | A-bus read data, same cycle |
| b_addr_o | output | 16 | B-bus full address |
| b_rd_o | output | 1 | B-bus read strobe |
| b_wr_o | output | 1 | B-bus write strobe |
| b_wdata_o | output | 8 | B-bus write data |
| b_rdata_i | input | 8 | B-bus read data, same cycle |
| busy_o | output | 1 | Engine running |
| stall_o | output | 1 | Processor stall request |
| chan_en_o | output | NCH | Live channel enable bits |
| clk_cnt_o | output | CYC_W | Clocks spent in the current or last run |

## Verification
A wrong slot phase or a wrong byte count shows up at the ports as a write strobe outside its expected busy cycle. It also shifts the final `clk_cnt_o` by a multiple of 8, and the first bad strobe appears within one byte slot of the fault. A stale pipeline stage or a wrong offset mode shows up as a wrong address or wrong data on the next write strobe. A filter fault shows up as a strobe on a blocked address, or as a missing or extra write event in the ordered event list. A fault in the enable mask or in channel selection shows up when `chan_en_o` is sampled at the first cycle after the first channel finishes, or as events in the wrong channel order.

// File: rtl/gpdma_pkg.sv
`timescale 1ns/1ps
package gpdma_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_OVH  = 2'd1,
        ST_XFER = 2'd2
    } dma_state_e;

    // Peripheral window base, added to the 8-bit register index
    localparam logic [15:0] BWIN_BASE = 16'h2100;
    localparam int unsigned SLOT_LAST = 7;
    localparam int unsigned RD_PHASE  = 0;
    localparam int unsigned WR_PHASE  = 4;
endpackage

// File: rtl/gpdma_guard.sv
`timescale 1ns/1ps
module gpdma_guard (
    input  logic [23:0] addr_i,
    input  logic [7:0]  bsel_i,
    output logic        a_ok_o,
    output logic        x_ok_o
);
    logic low_half;
    logic blk;
    logic wram;
    logic unused_bits;

    assign low_half = !addr_i[22];
    // Register windows reachable only in the lower half of the bank space
    assign blk = low_half && ((addr_i[15:8] == 8'h21)  ||
                              (addr_i[15:9] == 7'h20)  ||
                              (addr_i[15:5] == 11'h210) ||
                              (addr_i[15:7] == 9'h086));
    assign wram = (addr_i[23:17] == 7'h3F) || (low_half && (addr_i[15:13] == 3'b000));
    assign a_ok_o = !blk;
    assign x_ok_o = !((bsel_i == 8'h80) && wram);
    assign unused_bits = ^{addr_i[16], addr_i[4:0]};
endmodule

// File: rtl/gpdma_boffset.sv
`timescale 1ns/1ps
module gpdma_boffset (
    input  logic [2:0] mode_i,
    input  logic [1:0] idx_i,
    output logic [1:0] off_o
);
    always_comb begin
        case (mode_i)
            3'd1, 3'd5: off_o = {1'b0, idx_i[0]};
            3'd3, 3'd7: off_o = {1'b0, idx_i[1]};
            3'd4:       off_o = idx_i;
            default:    off_o = 2'd0;
        endcase
    end
endmodule

// File: rtl/gpdma_pick.sv
`timescale 1ns/1ps
module gpdma_pick #(
    parameter int NCH  = 8,
    parameter int CH_W = $clog2(NCH)
) (
    input  logic [NCH-1:0]  mask_i,
    output logic            found_o,
    output logic [CH_W-1:0] idx_o
);
    // Lowest set bit wins: scan downward so the last hit is the smallest
    always_comb begin
        found_o = 1'b0;
        idx_o   = '0;
        for (int i = NCH - 1; i >= 0; i--) begin
            if (mask_i[i]) begin
                found_o = 1'b1;
                idx_o   = CH_W'(i);
            end
        end
    end
endmodule

// File: rtl/gpdma_engine.sv
`timescale 1ns/1ps
module gpdma_engine
    import gpdma_pkg::*;
#(
    parameter int NCH   = 8,
    parameter int CNT_W = 16,
    parameter int CYC_W = 32
) (
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic                 start_i,
    input  logic [NCH-1:0]       en_mask_i,
    input  logic [NCH-1:0]       cfg_dir_i,
    input  logic [3*NCH-1:0]     cfg_mode_i,
    input  logic [NCH-1:0]       cfg_fixed_i,
    input  logic [NCH-1:0]       cfg_rev_i,
    input  logic [8*NCH-1:0]     cfg_bank_i,
    input  logic [16*NCH-1:0]    cfg_addr_i,
    input  logic [8*NCH-1:0]     cfg_bbase_i,
    input  logic [CNT_W*NCH-1:0] cfg_count_i,
    output logic [23:0]          a_addr_o,
    output logic                 a_rd_o,
    output logic                 a_wr_o,
    output logic [7:0]           a_wdata_o,
    input  logic [7:0]           a_rdata_i,
    output logic [15:0]          b_addr_o,
    output logic                 b_rd_o,
    output logic                 b_wr_o,
    output logic [7:0]           b_wdata_o,
    input  logic [7:0]           b_rdata_i,
    output logic                 busy_o,
    output logic                 stall_o,
    output logic [NCH-1:0]       chan_en_o,
    output logic [CYC_W-1:0]     clk_cnt_o
);
    localparam int CH_W = $clog2(NCH);
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);
    localparam logic [CYC_W-1:0] CYC_ONE = CYC_W'(1);
    localparam logic [NCH-1:0]   CH_ONE  = NCH'(1);
    localparam logic [2:0]       PH_RD   = 3'(RD_PHASE);
    localparam logic [2:0]       PH_WR   = 3'(WR_PHASE);
    localparam logic [2:0]       PH_END  = 3'(SLOT_LAST);

    typedef struct packed {
        dma_state_e       st;
        logic [2:0]       ph;
        logic [CH_W-1:0]  ch;
        logic             tail;
        logic [NCH-1:0]   en;
        logic [15:0]      addr;
        logic [CNT_W-1:0] cnt;
        logic [1:0]       idx;
        logic [7:0]       mdr;
        logic             pv;
        logic             pside;
        logic [23:0]      paddr;
        logic [7:0]       pdata;
        logic [CYC_W-1:0] cyc;
    } regs_t;

    regs_t r_q, r_d;

    // Per-channel settings unpacked from the flat ports
    logic             dir_a   [NCH];
    logic             fix_a   [NCH];
    logic             rev_a   [NCH];
    logic [2:0]       mode_a  [NCH];
    logic [7:0]       bank_a  [NCH];
    logic [15:0]      addr_a  [NCH];
    logic [7:0]       bbase_a [NCH];
    logic [CNT_W-1:0] cnt_a   [NCH];

    for (genvar g = 0; g < NCH; g++) begin : g_unpack
        assign dir_a[g]   = cfg_dir_i[g];
        assign fix_a[g]   = cfg_fixed_i[g];
        assign rev_a[g]   = cfg_rev_i[g];
        assign mode_a[g]  = cfg_mode_i[3*g +: 3];
        assign bank_a[g]  = cfg_bank_i[8*g +: 8];
        assign addr_a[g]  = cfg_addr_i[16*g +: 16];
        assign bbase_a[g] = cfg_bbase_i[8*g +: 8];
        assign cnt_a[g]   = cfg_count_i[CNT_W*g +: CNT_W];
    end

    logic            cur_dir;
    logic [23:0]     a_cur;
    logic [1:0]      b_off;
    logic [7:0]      b_cur;
    logic            a_ok, x_ok;
    logic [NCH-1:0]  mask_next;
    logic            pick_found;
    logic [CH_W-1:0] pick_idx;
    logic [7:0]      rd_data;

    assign cur_dir = dir_a[r_q.ch];
    assign a_cur   = {bank_a[r_q.ch], r_q.addr};
    assign b_cur   = bbase_a[r_q.ch] + {6'b0, b_off};

    gpdma_boffset u_boff (
        .mode_i (mode_a[r_q.ch]),
        .idx_i  (r_q.idx),
        .off_o  (b_off)
    );

    gpdma_guard u_rd_guard (
        .addr_i (a_cur),
        .bsel_i (b_cur),
        .a_ok_o (a_ok),
        .x_ok_o (x_ok)
    );

    assign mask_next = r_q.en & ~(r_q.tail ? (CH_ONE << r_q.ch) : '0);

    gpdma_pick #(.NCH(NCH), .CH_W(CH_W)) u_pick (
        .mask_i  (mask_next),
        .found_o (pick_found),
        .idx_o   (pick_idx)
    );

    assign rd_data = cur_dir ? (x_ok ? b_rdata_i : 8'h00) : (a_ok ? a_rdata_i : 8'h00);

    always_comb begin
        r_d = r_q;
        unique case (r_q.st)
            ST_IDLE: begin
                if (start_i) begin
                    r_d.st   = ST_OVH;
                    r_d.ph   = '0;
                    r_d.tail = 1'b0;
                    r_d.en   = en_mask_i;
                    r_d.cyc  = '0;
                    r_d.pv   = 1'b0;
                end
            end
            ST_OVH: begin
                r_d.cyc = r_q.cyc + CYC_ONE;
                r_d.ph  = r_q.ph + 3'd1;
                if (r_q.ph == PH_WR) r_d.pv = 1'b0;
                if (r_q.ph == PH_END) begin
                    r_d.en   = mask_next;
                    r_d.tail = 1'b0;
                    if (pick_found) begin
                        r_d.st   = ST_XFER;
                        r_d.ch   = pick_idx;
                        r_d.addr = addr_a[pick_idx];
                        r_d.cnt  = cnt_a[pick_idx];
                        r_d.idx  = '0;
                    end else begin
                        r_d.st = ST_IDLE;
                    end
                end
            end
            ST_XFER: begin
                r_d.cyc = r_q.cyc + CYC_ONE;
                r_d.ph  = r_q.ph + 3'd1;
                if (r_q.ph == PH_RD) r_d.mdr = rd_data;
                if (r_q.ph == PH_WR) begin
                    r_d.pv    = cur_dir ? a_ok : x_ok;
                    r_d.pside = cur_dir;
                    r_d.paddr = cur_dir ? a_cur : {8'h00, BWIN_BASE + {8'h00, b_cur}};
                    r_d.pdata = r_q.mdr;
                end
                if (r_q.ph == PH_END) begin
                    if (!fix_a[r_q.ch]) begin
                        r_d.addr = rev_a[r_q.ch] ? r_q.addr - 16'd1 : r_q.addr + 16'd1;
                    end
                    r_d.cnt = r_q.cnt - CNT_ONE;
                    r_d.idx = r_q.idx + 2'd1;
                    if (r_q.cnt == CNT_ONE) begin
                        r_d.st   = ST_OVH;
                        r_d.tail = 1'b1;
                    end
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) r_q <= '0;
        else         r_q <= r_d;
    end

    logic wr_slot, rd_slot;
    assign wr_slot   = (r_q.st != ST_IDLE) && (r_q.ph == PH_WR) && r_q.pv;
    assign rd_slot   = (r_q.st == ST_XFER) && (r_q.ph == PH_RD);
    assign a_wr_o    = wr_slot && r_q.pside;
    assign b_wr_o    = wr_slot && !r_q.pside;
    assign a_rd_o    = rd_slot && !cur_dir && a_ok;
    assign b_rd_o    = rd_slot && cur_dir && x_ok;
    assign a_addr_o  = a_wr_o ? r_q.paddr : a_cur;
    assign b_addr_o  = b_wr_o ? r_q.paddr[15:0] : (BWIN_BASE + {8'h00, b_cur});
    assign a_wdata_o = r_q.pdata;
    assign b_wdata_o = r_q.pdata;
    assign busy_o    = (r_q.st != ST_IDLE);
    assign stall_o   = busy_o;
    assign chan_en_o = r_q.en;
    assign clk_cnt_o = r_q.cyc;

    // Independent filter on the address actually driven during writes
    logic wr_a_ok, unused_wr_x;
    gpdma_guard u_wr_guard (
        .addr_i (a_addr_o),
        .bsel_i (8'h00),
        .a_ok_o (wr_a_ok),
        .x_ok_o (unused_wr_x)
    );

    assert_order_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (r_q.st == ST_OVH && r_q.tail && r_q.ph == PH_END && pick_found) |=> (r_q.ch > $past(r_q.ch)));

    assert_en_clear_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (r_q.st == ST_OVH && r_q.tail && r_q.ph == PH_END) |=> !r_q.en[$past(r_q.ch)]);

    assert_rd_slot_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (a_rd_o || b_rd_o) |-> (r_q.st == ST_XFER && r_q.ph == PH_RD));

    assert_hold_addr_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (r_q.st == ST_XFER && r_q.ph == PH_END && fix_a[r_q.ch]) |=> (r_q.addr == $past(r_q.addr)));

    assert_down_addr_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (r_q.st == ST_XFER && r_q.ph == PH_END && !fix_a[r_q.ch] && rev_a[r_q.ch])
        |=> (r_q.addr == $past(r_q.addr) - 16'd1));

    assert_last_byte_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (r_q.st == ST_XFER && r_q.ph == PH_END && r_q.cnt == CNT_ONE) |=> (r_q.st == ST_OVH && r_q.tail));

    assert_blocked_wr_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        a_wr_o |-> wr_a_ok);

    assert_wr_slot_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (a_wr_o || b_wr_o) |-> (r_q.ph == PH_WR && !(a_wr_o && b_wr_o)));

    assert_start_ignored_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (busy_o && start_i && !(r_q.st == ST_OVH && r_q.ph == PH_END)) |=> (r_q.en == $past(r_q.en)));
endmodule

// File: tb/gpdma_engine_test.sv
`timescale 1ns/1ps
module gpdma_engine_test;
    localparam int NCH = 8;
    localparam int CW  = 10;
    localparam int YW  = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic            start = 1'b0;
    logic [7:0]      en_mask = '0;
    logic [7:0]      c_dir = '0, c_fixed = '0, c_rev = '0;
    logic [23:0]     c_mode = '0;
    logic [63:0]     c_bank = '0, c_bbase = '0;
    logic [127:0]    c_addr = '0;
    logic [CW*8-1:0] c_cnt = '0;

    logic [23:0] a_addr;  logic a_rd, a_wr; logic [7:0] a_wdata, a_rdata;
    logic [15:0] b_addr;  logic b_rd, b_wr; logic [7:0] b_wdata, b_rdata;
    logic busy, stall;    logic [7:0] chan_en; logic [YW-1:0] clk_cnt;

    function automatic logic [7:0] fa(input logic [23:0] a);
        return a[7:0] ^ a[15:8] ^ a[23:16] ^ 8'h5A;
    endfunction
    function automatic logic [7:0] fb(input logic [15:0] b);
        return b[7:0] * 8'd3 + 8'd1;
    endfunction
    function automatic bit blocked(input logic [23:0] a);
        logic [15:0] o = a[15:0];
        if (a[22]) return 0;
        return (o >= 16'h2100 && o <= 16'h21FF) || (o >= 16'h4000 && o <= 16'h41FF) ||
               (o >= 16'h4200 && o <= 16'h421F) || (o >= 16'h4300 && o <= 16'h437F);
    endfunction
    function automatic bit in_wram(input logic [23:0] a);
        return (a[23:16] == 8'h7E) || (a[23:16] == 8'h7F) || (!a[22] && a[15:0] < 16'h2000);
    endfunction
    function automatic logic [1:0] boff(input logic [2:0] m, input int k);
        case (m)
            3'd1, 3'd5: return 2'(k % 2);
            3'd3, 3'd7: return 2'((k / 2) % 2);
            3'd4:       return 2'(k % 4);
            default:    return 2'd0;
        endcase
    endfunction

    assign a_rdata = fa(a_addr);
    assign b_rdata = fb(b_addr);

    gpdma_engine #(.NCH(NCH), .CNT_W(CW), .CYC_W(YW)) uut (
        .clk_i(clk), .rst_ni(rst_n), .start_i(start), .en_mask_i(en_mask),
        .cfg_dir_i(c_dir), .cfg_mode_i(c_mode), .cfg_fixed_i(c_fixed), .cfg_rev_i(c_rev),
        .cfg_bank_i(c_bank), .cfg_addr_i(c_addr), .cfg_bbase_i(c_bbase), .cfg_count_i(c_cnt),
        .a_addr_o(a_addr), .a_rd_o(a_rd), .a_wr_o(a_wr), .a_wdata_o(a_wdata), .a_rdata_i(a_rdata),
        .b_addr_o(b_addr), .b_rd_o(b_rd), .b_wr_o(b_wr), .b_wdata_o(b_wdata), .b_rdata_i(b_rdata),
        .busy_o(busy), .stall_o(stall), .chan_en_o(chan_en), .clk_cnt_o(clk_cnt)
    );

    typedef struct packed {
        logic        side;
        logic [23:0] addr;
        logic [7:0]  data;
        logic [31:0] stamp;
    } ev_t;
    ev_t act_q[$];
    ev_t exp_q[$];

    int tests = 0, fails = 0;
    int stamp = 0, total = 0;
    int chk_stamp = -1; logic [7:0] chk_en = '0; bit chk_seen = 0; logic [7:0] chk_got = '0;
    int rd_viol = 0, stall_viol = 0;
    int wd = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    always @(posedge clk) begin
        wd++;
        if (wd > 190000) begin
            fails++; tests++;
            $display("FAIL watchdog: actual %0d cycles expected below 190000", wd);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    always @(negedge clk) begin
        if (stall !== busy) stall_viol++;
        if (busy) begin
            if (a_wr) act_q.push_back('{1'b1, a_addr, a_wdata, 32'(stamp)});
            if (b_wr) act_q.push_back('{1'b0, {8'h00, b_addr}, b_wdata, 32'(stamp)});
            if (a_rd && blocked(a_addr)) rd_viol++;
            if (b_rd && b_addr[7:0] == 8'h80 && in_wram(a_addr)) rd_viol++;
            if (stamp == chk_stamp) begin chk_seen = 1; chk_got = chan_en; end
            stamp++;
        end
    end

    task automatic set_ch(input int c, input logic d, input logic [2:0] m, input logic fx,
                          input logic rv, input logic [7:0] bk, input logic [15:0] ad,
                          input logic [7:0] bb, input logic [CW-1:0] n);
        c_dir[c] = d; c_fixed[c] = fx; c_rev[c] = rv; c_mode[3*c +: 3] = m;
        c_bank[8*c +: 8] = bk; c_addr[16*c +: 16] = ad; c_bbase[8*c +: 8] = bb;
        c_cnt[CW*c +: CW] = n;
    endtask

    task automatic build(input logic [7:0] mask);
        int base = 8;
        bit first = 1;
        exp_q.delete();
        chk_stamp = -1;
        for (int c = 0; c < 8; c++) begin
            if (mask[c]) begin
                int n = (c_cnt[CW*c +: CW] == 0) ? (1 << CW) : int'(c_cnt[CW*c +: CW]);
                logic [15:0] ad = c_addr[16*c +: 16];
                for (int k = 0; k < n; k++) begin
                    logic [7:0]  b  = c_bbase[8*c +: 8] + {6'b0, boff(c_mode[3*c +: 3], k)};
                    logic [23:0] a  = {c_bank[8*c +: 8], ad};
                    bit          xb = (b == 8'h80) && in_wram(a);
                    logic [15:0] bf = 16'h2100 + {8'h00, b};
                    logic [31:0] st = 32'(base + 8*k + 12);
                    if (!c_dir[c]) begin
                        if (!xb) exp_q.push_back('{1'b0, {8'h00, bf}, blocked(a) ? 8'h00 : fa(a), st});
                    end else begin
                        if (!blocked(a)) exp_q.push_back('{1'b1, a, xb ? 8'h00 : fb(bf), st});
                    end
                    if (!c_fixed[c]) ad = c_rev[c] ? ad - 16'd1 : ad + 16'd1;
                end
                base += 8*n + 8;
                if (first) begin
                    first = 0;
                    if ((mask >> (c + 1)) != 0) begin
                        chk_stamp = base;
                        chk_en = mask & ~(8'd1 << c);
                    end
                end
            end
        end
        total = base;
    endtask

    task automatic run(input logic [7:0] mask, input string lbl, input bit restart_mid);
        act_q.delete();
        build(mask);
        chk_seen = 0; rd_viol = 0; stall_viol = 0;
        @(negedge clk);
        stamp = 0; start = 1'b1; en_mask = mask;
        @(negedge clk);
        start = 1'b0; en_mask = 8'h00;
        if (restart_mid) begin
            repeat (20) @(negedge clk);
            start = 1'b1; en_mask = 8'hFF;
            @(negedge clk);
            start = 1'b0; en_mask = 8'h00;
        end
        while (busy) @(negedge clk);
        check(act_q.size() == exp_q.size(), lbl, "write event count", act_q.size(), exp_q.size());
        for (int i = 0; i < act_q.size() && i < exp_q.size(); i++) begin
            check(act_q[i].side == exp_q[i].side && act_q[i].addr == exp_q[i].addr, lbl,
                  "write side/address", {act_q[i].side, act_q[i].addr}, {exp_q[i].side, exp_q[i].addr});
            check(act_q[i].data == exp_q[i].data, "R12", "write data", act_q[i].data, exp_q[i].data);
            check(act_q[i].stamp == exp_q[i].stamp, "R9", "write cycle", act_q[i].stamp, exp_q[i].stamp);
        end
        check(clk_cnt == YW'(total), "R3", "clock count", clk_cnt, total);
        check(stamp == total, "R3", "busy duration", stamp, total);
        check(chan_en == 8'h00, "R2", "enables after run", chan_en, 0);
        if (chk_stamp >= 0)
            check(chk_seen && chk_got == chk_en, "R2", "enables after first channel", chk_got, chk_en);
        check(rd_viol == 0, "R7/R8", "read strobes on blocked targets", rd_viol, 0);
        check(stall_viol == 0, "R10", "stall tracks busy", stall_viol, 0);
    endtask

    function automatic logic [7:0] pick_bank();
        case ($urandom_range(0, 5))
            0: return 8'h00;  1: return 8'h7E;  2: return 8'h40;
            3: return 8'h80;  4: return 8'hC0;  default: return 8'($urandom);
        endcase
    endfunction
    function automatic logic [15:0] pick_addr();
        case ($urandom_range(0, 7))
            0: return 16'h20FE; 1: return 16'h41FD; 2: return 16'h421E; 3: return 16'h437E;
            4: return 16'h1FFE; 5: return 16'hFFFE; 6: return 16'h0001;
            default: return 16'($urandom);
        endcase
    endfunction
    function automatic logic [7:0] pick_bb();
        case ($urandom_range(0, 3))
            0: return 8'h80; 1: return 8'h7F; 2: return 8'hFF;
            default: return 8'($urandom);
        endcase
    endfunction

    task automatic rand_cfg();
        for (int c = 0; c < 8; c++)
            set_ch(c, 1'($urandom_range(0, 1)), 3'($urandom_range(0, 7)),
                   $urandom_range(0, 3) == 0, 1'($urandom_range(0, 1)),
                   pick_bank(), pick_addr(), pick_bb(), CW'($urandom_range(1, 12)));
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (5) @(negedge clk);
        // reset state
        check(busy == 1'b0 && stall == 1'b0, "R10", "busy/stall in reset", {busy, stall}, 0);
        check({a_rd, a_wr, b_rd, b_wr} == 4'b0, "R3", "strobes in reset", {a_rd, a_wr, b_rd, b_wr}, 0);
        check(chan_en == 8'h00, "R2", "enables in reset", chan_en, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(clk_cnt == '0 && busy == 1'b0, "R3", "idle after reset", clk_cnt, 0);

        // empty mask: only the leading overhead
        run(8'h00, "R3", 0);

        // every offset mode on one channel, A to B
        for (int m = 0; m < 8; m++) begin
            set_ch(3, 1'b0, 3'(m), 1'b0, 1'b0, 8'h80, 16'h8000, 8'h10, CW'(8));
            run(8'h08, "R4", 0);
        end

        // B index wrap past 0xFF
        set_ch(2, 1'b0, 3'd4, 1'b0, 1'b0, 8'h80, 16'h9000, 8'hFE, CW'(6));
        run(8'h04, "R11", 0);

        // count-down across zero and held address, B to A
        set_ch(5, 1'b1, 3'd1, 1'b0, 1'b1, 8'h90, 16'h0001, 8'h20, CW'(4));
        set_ch(6, 1'b1, 3'd0, 1'b1, 1'b0, 8'hA0, 16'h5555, 8'h30, CW'(3));
        run(8'h60, "R5", 0);

        // blocked register windows in both directions, and upper-half bank
        set_ch(0, 1'b0, 3'd0, 1'b0, 1'b0, 8'h00, 16'h20FF, 8'h05, CW'(3));
        set_ch(1, 1'b1, 3'd0, 1'b0, 1'b0, 8'h80, 16'h41FE, 8'h06, CW'(4));
        set_ch(2, 1'b0, 3'd0, 1'b0, 1'b0, 8'h40, 16'h2100, 8'h07, CW'(2));
        set_ch(4, 1'b1, 3'd0, 1'b0, 1'b0, 8'h00, 16'h437E, 8'h08, CW'(3));
        run(8'h17, "R7", 0);

        // work-memory conflicts with index 0x80
        set_ch(0, 1'b0, 3'd0, 1'b0, 1'b0, 8'h7E, 16'h1234, 8'h80, CW'(3));
        set_ch(1, 1'b1, 3'd0, 1'b0, 1'b0, 8'h00, 16'h1FFE, 8'h80, CW'(4));
        set_ch(2, 1'b0, 3'd1, 1'b0, 1'b0, 8'h7F, 16'h0010, 8'h7F, CW'(4));
        run(8'h07, "R8", 0);

        // count of zero copies 2^CNT_W bytes
        set_ch(7, 1'b0, 3'd4, 1'b0, 1'b0, 8'h80, 16'h9000, 8'h00, CW'(0));
        run(8'h80, "R6", 0);

        // start while busy is ignored
        rand_cfg();
        run(8'h05, "R10", 1);

        // random channel sets, ordering and everything else
        for (int t = 0; t < 30; t++) begin
            rand_cfg();
            run((t % 3 == 0) ? 8'hFF : 8'($urandom), "R1", 0);
        end

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule